// File: doc/BRIEF.md
# Prioritized dual-target interrupt controller

The block collects a small set of level-sensitive interrupt inputs and steers each one to one of two processor request lines: a normal request (IRQ) or a fast request (FIQ). Every source owns a configuration register that holds its enable, input polarity, target select, priority level and a software-raised pending flag. For each target, the block picks the enabled, active source with the highest priority above that target's threshold. It then asserts the target's request line and presents a vector equal to the target's base register plus eight times the winning slot number.

Software reaches the block through a simple single-cycle register bus. A write lands at the clock edge and a read returns data in the same cycle. Each configuration field in a source register has its own write-enable bit. A driver can therefore enable, disable or acknowledge a source without first reading the rest of its settings back. Slot 0 is reserved, so input line `src_in[n]` belongs to slot n+1.

Top module: `intc_top`

## Requirements
- R1: After reset every source is disabled with priority 0, target IRQ, active-high polarity and no software pending flag. Both thresholds and both vector bases read 0, and both request lines are low with vectors 0.
- R2: In a write to a source register, a field changes only when its write-enable bit is 1: bit 26 for priority (bits 3:0), bit 27 for target (bit 8), bit 28 for enable (bit 9), bit 29 for polarity (bit 10). Fields whose write-enable bit is 0 keep their stored values.
- R3: The register map is: thresholds of IRQ at address 0 and FIQ at address 1, vector bases of IRQ at 2 and FIQ at 3, and source slot s at address 32+s. Slot 0 reads 0 and ignores writes, and input `src_in[n]` drives slot n+1.
- R4: With the polarity bit at 1 (active low) the source input is inverted before it is evaluated. With it at 0 the input is active high.
- R5: A source competes only when it is enabled, its corrected input or its software flag is 1, and its priority is strictly greater than its target's threshold. A threshold of 0 masks nothing on priority grounds, and priority 0 never wins.
- R6: Among competing sources the highest priority wins, and on equal priority the lowest slot number wins.
- R7: A target's vector equals its base plus 8 times the winning slot number. With no winner the request line is low and the vector equals the base.
- R8: A source with target bit 0 competes only for IRQ and one with target bit 1 only for FIQ.
- R9: Writing 1 to bit 30 sets the source's software pending flag and writing 1 to bit 25 clears it. When both are 1 in the same write the flag ends cleared, and the enable can be kept on by the same write.
- R10: Reading a source register returns priority (3:0), target (8), enable (9), polarity (10) and the software flag (11). Bit 16 returns the live pending status, which is the corrected input OR the software flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| src_in | input | NUM_SRC | Raw interrupt inputs, bit n feeds slot n+1 |
| irq_req | output | 1 | Normal interrupt request |
| irq_vec | output | 32 | Vector for the normal request |
| fiq_req | output | 1 | Fast interrupt request |
| fiq_vec | output | 32 | Vector for the fast request |

## Verification
The bench builds the block with its defaults: 16 sources, 4-bit priorities and a 6-bit address. At that size every slot, every priority level and every threshold value can be swept in a few thousand cycles. The sweep rewrites random sources and input patterns and steps both thresholds through all 16 values. That makes ties, priorities equal to a threshold, and sources routed to the other target all appear many times. The bench compares the result against a reference winner computed from its own copy of the configuration.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int BUS_W = 32;

    // source register field positions
    localparam int F_PRIO_LSB = 0;
    localparam int F_TGT      = 8;
    localparam int F_EN       = 9;
    localparam int F_POL      = 10;
    localparam int F_SWP      = 11;
    localparam int F_LIVE     = 16;
    localparam int F_CLR      = 25;
    localparam int F_WE_PRIO  = 26;
    localparam int F_WE_TGT   = 27;
    localparam int F_WE_EN    = 28;
    localparam int F_WE_POL   = 29;
    localparam int F_SET      = 30;

    // control register word addresses
    localparam int A_THR_IRQ  = 0;
    localparam int A_THR_FIQ  = 1;
    localparam int A_BASE_IRQ = 2;
    localparam int A_BASE_FIQ = 3;

    typedef enum logic {
        TGT_IRQ = 1'b0,
        TGT_FIQ = 1'b1
    } tgt_e;
endpackage

// File: rtl/intc_src_slot.sv
module intc_src_slot #(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              we_prio,
    input  logic              we_tgt,
    input  logic              we_en,
    input  logic              we_pol,
    input  logic              sw_set,
    input  logic              sw_clr,
    input  logic [PRIO_W-1:0] new_prio,
    input  logic              new_tgt,
    input  logic              new_en,
    input  logic              new_pol,
    input  logic              raw_in,
    output logic [PRIO_W-1:0] prio_o,
    output logic              tgt_o,
    output logic              en_o,
    output logic              pol_o,
    output logic              swp_o,
    output logic              live_o,
    output logic              active_o
);
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              tgt;
        logic              en;
        logic              pol;
        logic              swp;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (we_prio) st_d.prio = new_prio;
            if (we_tgt)  st_d.tgt  = new_tgt;
            if (we_en)   st_d.en   = new_en;
            if (we_pol)  st_d.pol  = new_pol;
            if (sw_set)  st_d.swp  = 1'b1;
            if (sw_clr)  st_d.swp  = 1'b0;   // clear dominates set
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prio_o   = st_q.prio;
    assign tgt_o    = st_q.tgt;
    assign en_o     = st_q.en;
    assign pol_o    = st_q.pol;
    assign swp_o    = st_q.swp;
    assign live_o   = (raw_in ^ st_q.pol) | st_q.swp;
    assign active_o = st_q.en & live_o;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter bit TARGET  = 1'b0
) (
    input  logic [NUM_SRC-1:0]             active,
    input  logic [NUM_SRC-1:0]             tgt,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              thr,
    input  logic [BUS_W-1:0]               base,
    output logic                           req,
    output logic [BUS_W-1:0]               vec
);
    localparam int IDX_W = $clog2(NUM_SRC + 1);

    logic [IDX_W-1:0]  best;
    logic [PRIO_W-1:0] best_p;

    // ascending scan with strict compare keeps the lowest slot on ties
    always_comb begin
        best   = '0;
        best_p = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (active[k] && (tgt[k] == TARGET) && (prio[k] > thr) && (prio[k] > best_p)) begin
                best   = IDX_W'(k + 1);
                best_p = prio[k];
            end
        end
    end

    assign req = (best != '0);
    assign vec = base + (BUS_W'(best) << 3);
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_req,
    output logic [BUS_W-1:0]   irq_vec,
    output logic               fiq_req,
    output logic [BUS_W-1:0]   fiq_vec
);
    localparam int REQ_BASE = 2 ** (ADDR_W - 1);

    typedef struct packed {
        logic [1:0][PRIO_W-1:0] thr;
        logic [1:0][BUS_W-1:0]  base;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                           wr_cyc;
    logic [1:0][PRIO_W-1:0]         thr_v;
    logic [1:0][BUS_W-1:0]          base_v;
    logic [NUM_SRC-1:0][PRIO_W-1:0] s_prio;
    logic [NUM_SRC-1:0]             s_tgt, s_en, s_pol, s_swp, s_live, s_act;
    logic [1:0]                     arb_req;
    logic [1:0][BUS_W-1:0]          arb_vec;

    assign wr_cyc = bus_sel && bus_we;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_cyc) begin
            case (bus_addr)
                ADDR_W'(A_THR_IRQ):  ctl_d.thr[0]  = bus_wdata[PRIO_W-1:0];
                ADDR_W'(A_THR_FIQ):  ctl_d.thr[1]  = bus_wdata[PRIO_W-1:0];
                ADDR_W'(A_BASE_IRQ): ctl_d.base[0] = bus_wdata;
                ADDR_W'(A_BASE_FIQ): ctl_d.base[1] = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign thr_v  = ctl_q.thr;
    assign base_v = ctl_q.base;

    // slot k+1 holds source k; slot 0 has no storage
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
        logic hit;
        assign hit = wr_cyc && (bus_addr == ADDR_W'(REQ_BASE + k + 1));

        intc_src_slot #(.PRIO_W(PRIO_W)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (hit),
            .we_prio  (bus_wdata[F_WE_PRIO]),
            .we_tgt   (bus_wdata[F_WE_TGT]),
            .we_en    (bus_wdata[F_WE_EN]),
            .we_pol   (bus_wdata[F_WE_POL]),
            .sw_set   (bus_wdata[F_SET]),
            .sw_clr   (bus_wdata[F_CLR]),
            .new_prio (bus_wdata[F_PRIO_LSB +: PRIO_W]),
            .new_tgt  (bus_wdata[F_TGT]),
            .new_en   (bus_wdata[F_EN]),
            .new_pol  (bus_wdata[F_POL]),
            .raw_in   (src_in[k]),
            .prio_o   (s_prio[k]),
            .tgt_o    (s_tgt[k]),
            .en_o     (s_en[k]),
            .pol_o    (s_pol[k]),
            .swp_o    (s_swp[k]),
            .live_o   (s_live[k]),
            .active_o (s_act[k])
        );
    end

    for (genvar t = 0; t < 2; t++) begin : g_arb
        intc_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .TARGET  (t == 1)
        ) arb_i (
            .active (s_act),
            .tgt    (s_tgt),
            .prio   (s_prio),
            .thr    (thr_v[t]),
            .base   (base_v[t]),
            .req    (arb_req[t]),
            .vec    (arb_vec[t])
        );
    end

    assign irq_req = arb_req[TGT_IRQ];
    assign irq_vec = arb_vec[TGT_IRQ];
    assign fiq_req = arb_req[TGT_FIQ];
    assign fiq_vec = arb_vec[TGT_FIQ];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                ADDR_W'(A_THR_IRQ):  bus_rdata[PRIO_W-1:0] = thr_v[0];
                ADDR_W'(A_THR_FIQ):  bus_rdata[PRIO_W-1:0] = thr_v[1];
                ADDR_W'(A_BASE_IRQ): bus_rdata = base_v[0];
                ADDR_W'(A_BASE_FIQ): bus_rdata = base_v[1];
                default: ;
            endcase
            for (int k = 0; k < NUM_SRC; k++) begin
                if (bus_addr == ADDR_W'(REQ_BASE + k + 1)) begin
                    bus_rdata[F_PRIO_LSB +: PRIO_W] = s_prio[k];
                    bus_rdata[F_TGT]  = s_tgt[k];
                    bus_rdata[F_EN]   = s_en[k];
                    bus_rdata[F_POL]  = s_pol[k];
                    bus_rdata[F_SWP]  = s_swp[k];
                    bus_rdata[F_LIVE] = s_live[k];
                end
            end
        end
    end
endmodule

// File: rtl/intc_top_chk.sv
module intc_top_chk
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 4,
    parameter int ADDR_W  = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_sel,
    input logic                   bus_we,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [BUS_W-1:0]       bus_wdata,
    input logic                   irq_req,
    input logic [BUS_W-1:0]       irq_vec,
    input logic                   fiq_req,
    input logic [BUS_W-1:0]       fiq_vec,
    input logic [1:0][PRIO_W-1:0] thr_v,
    input logic [1:0][BUS_W-1:0]  base_v,
    input logic [NUM_SRC-1:0]     s_en,
    input logic [NUM_SRC-1:0]     s_swp
);
    localparam int REQ_BASE = 2 ** (ADDR_W - 1);

    logic [BUS_W-1:0] off_irq, off_fiq;
    logic             slot1_wr;

    assign off_irq  = irq_vec - base_v[0];
    assign off_fiq  = fiq_vec - base_v[1];
    assign slot1_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(REQ_BASE + 1));

    // R7
    irq_idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_vec == base_v[0]);

    // R7
    fiq_idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_req |-> fiq_vec == base_v[1]);

    // R7
    irq_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (off_irq >= BUS_W'(8)) && (off_irq <= BUS_W'(8 * NUM_SRC)) && (off_irq[2:0] == 3'b000));

    // R7
    fiq_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req |-> (off_fiq >= BUS_W'(8)) && (off_fiq <= BUS_W'(8 * NUM_SRC)) && (off_fiq[2:0] == 3'b000));

    // R5
    irq_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&thr_v[0]) |-> !irq_req);

    // R5
    fiq_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&thr_v[1]) |-> !fiq_req);

    // R2
    keep_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot1_wr && !bus_wdata[F_WE_EN]) |=> $stable(s_en[0]));

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot1_wr && bus_wdata[F_CLR]) |=> !s_swp[0]);
endmodule

bind intc_top intc_top_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .fiq_req   (fiq_req),
    .fiq_vec   (fiq_vec),
    .thr_v     (thr_v),
    .base_v    (base_v),
    .s_en      (s_en),
    .s_swp     (s_swp)
);

// File: tb/intc_top_tb_top.sv
`timescale 1ns/1ps
module intc_top_tb_top;
    localparam int N   = 16;
    localparam int REQ = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] src_in = '0;
    logic        irq_req, fiq_req;
    logic [31:0] irq_vec, fiq_vec;

    int checks = 0;
    int errors = 0;

    // reference copy of the configuration
    logic [3:0]  m_prio [1:N];
    logic        m_tgt  [1:N];
    logic        m_en   [1:N];
    logic        m_pol  [1:N];
    logic        m_sw   [1:N];
    logic [3:0]  m_thr  [0:1];
    logic [31:0] m_base [0:1];
    logic [31:0] rs = 32'h1ACE_B00C;

    always #2.5 clk = ~clk;

    intc_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_req(irq_req), .irq_vec(irq_vec),
        .fiq_req(fiq_req), .fiq_vec(fiq_vec)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step_rand();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
    endtask

    function automatic logic [31:0] cfg(input int p, input int t, input int e, input int pl);
        return (32'h1 << 26) | (32'h1 << 27) | (32'h1 << 28) | (32'h1 << 29) |
               32'(p & 15) | (32'(t & 1) << 8) | (32'(e & 1) << 9) | (32'(pl & 1) << 10);
    endfunction

    function automatic logic [31:0] exp_rd(input int s);
        logic live;
        live = (src_in[s-1] ^ m_pol[s]) | m_sw[s];
        return 32'(m_prio[s]) | (32'(m_tgt[s]) << 8) | (32'(m_en[s]) << 9) |
               (32'(m_pol[s]) << 10) | (32'(m_sw[s]) << 11) | (32'(live) << 16);
    endfunction

    task automatic exp_target(input int t, output logic r, output logic [31:0] v);
        int best = 0;
        int bp = 0;
        for (int s = 1; s <= N; s++) begin
            if (m_en[s] && (int'(m_tgt[s]) == t) && (((src_in[s-1] ^ m_pol[s]) | m_sw[s]) == 1'b1)
                && (int'(m_prio[s]) > int'(m_thr[t])) && (int'(m_prio[s]) > bp)) begin
                best = s;
                bp = int'(m_prio[s]);
            end
        end
        r = (best != 0);
        v = m_base[t] + 32'(best * 8);
    endtask

    task automatic check_outs(input string tag);
        logic r0, r1;
        logic [31:0] v0, v1;
        exp_target(0, r0, v0);
        exp_target(1, r1, v1);
        check({tag, " irq_req"}, 32'(irq_req), 32'(r0));
        check({tag, " irq_vec"}, irq_vec, v0);
        check({tag, " fiq_req"}, 32'(fiq_req), 32'(r1));
        check({tag, " fiq_vec"}, fiq_vec, v1);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr_ctl(input int a, input logic [31:0] d);
        wr(a, d);
        if (a < 2) m_thr[a] = d[3:0];
        else       m_base[a-2] = d;
    endtask

    task automatic wr_req(input int s, input logic [31:0] d);
        wr(REQ + s, d);
        if (d[26]) m_prio[s] = d[3:0];
        if (d[27]) m_tgt[s]  = d[8];
        if (d[28]) m_en[s]   = d[9];
        if (d[29]) m_pol[s]  = d[10];
        if (d[30]) m_sw[s]   = 1'b1;
        if (d[25]) m_sw[s]   = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] q);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 6'(a);
        #1;
        q = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] q;
        for (int s = 1; s <= N; s++) begin
            m_prio[s] = '0; m_tgt[s] = 1'b0; m_en[s] = 1'b0; m_pol[s] = 1'b0; m_sw[s] = 1'b0;
        end
        m_thr[0] = '0; m_thr[1] = '0; m_base[0] = '0; m_base[1] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_req", 32'(irq_req), 0);
        check("R1 fiq_req", 32'(fiq_req), 0);
        check("R1 irq_vec", irq_vec, 0);
        check("R1 fiq_vec", fiq_vec, 0);
        for (int a = 0; a < 4; a++) begin
            rd(a, q);
            check("R1 control reg", q, 0);
        end
        for (int s = 1; s <= N; s++) begin
            rd(REQ + s, q);
            check("R1 source reg", q, 0);
        end

        // R3 slot 0 is inert, src_in[n] feeds slot n+1
        wr(REQ + 0, cfg(7, 0, 1, 0) | (32'h1 << 30));
        rd(REQ + 0, q);
        check("R3 slot0 read", q, 0);
        check_outs("R3 slot0 write");
        wr_req(3, cfg(5, 0, 1, 0));
        src_in = 16'h0004;
        #1;
        check("R3 src_in[2] to slot3 req", 32'(irq_req), 1);
        check("R3 src_in[2] to slot3 vec", irq_vec, 32'd24);

        // R4 active-low inversion
        wr_req(3, (32'h1 << 29) | (32'h1 << 10));
        #1;
        check("R4 high input masked", 32'(irq_req), 0);
        src_in = 16'h0000;
        #1;
        check("R4 low input active", 32'(irq_req), 1);
        check("R4 low input vec", irq_vec, 32'd24);

        // R2 per-field write enables
        wr_req(3, (32'h1 << 28) | 32'h10F);
        rd(REQ + 3, q);
        check("R2 only enable changed", q, 32'h0001_0405);
        wr_req(3, (32'h1 << 26) | 32'd9 | (32'h1 << 9));
        rd(REQ + 3, q);
        check("R2 only priority changed", q, 32'h0001_0409);
        wr_req(3, (32'h1 << 27) | (32'h1 << 8) | (32'h1 << 9));
        rd(REQ + 3, q);
        check("R2 only target changed", q, 32'h0001_0509);
        wr_req(3, (32'h1 << 28) | (32'h1 << 9));
        rd(REQ + 3, q);
        check("R10 readback", q, 32'h0001_0709);
        // R8 FIQ routing
        check("R8 fiq_req", 32'(fiq_req), 1);
        check("R8 fiq_vec", fiq_vec, 32'd24);
        check("R8 irq untouched", 32'(irq_req), 0);
        wr_req(3, (32'h1 << 28));

        // R5 eligibility and thresholds
        wr_req(4, cfg(0, 0, 1, 0));
        src_in = 16'h0008;
        #1;
        check("R5 priority 0 never wins", 32'(irq_req), 0);
        wr_req(4, cfg(3, 0, 1, 0));
        check("R5 threshold 0 passes", irq_vec, 32'd32);
        wr_ctl(0, 32'd3);
        check("R5 equal to threshold masked", 32'(irq_req), 0);
        wr_ctl(0, 32'd2);
        check("R5 above threshold", 32'(irq_req), 1);
        wr_ctl(0, 32'd0);

        // R6 tie and priority
        wr_req(9, cfg(3, 0, 1, 0));
        src_in = 16'h0108;
        #1;
        check("R6 tie lowest slot", irq_vec, 32'd32);
        wr_req(9, cfg(4, 0, 1, 0));
        check("R6 higher priority", irq_vec, 32'd72);
        // R7 base offset
        wr_ctl(2, 32'h0000_1000);
        check("R7 base plus index", irq_vec, 32'h0000_1048);
        wr_req(4, (32'h1 << 28));
        wr_req(9, (32'h1 << 28));
        check("R7 idle vector is base", irq_vec, 32'h0000_1000);

        // R9 software pending
        src_in = 16'h0000;
        wr_req(12, cfg(2, 1, 1, 0) | (32'h1 << 30));
        check("R9 sw raises fiq", fiq_vec, 32'd96);
        rd(REQ + 12, q);
        check("R9 sw flag read", q, 32'h0001_0B02);
        wr_req(12, (32'h1 << 25) | (32'h1 << 28) | (32'h1 << 9));
        check("R9 clear drops fiq", 32'(fiq_req), 0);
        wr_req(12, (32'h1 << 30) | (32'h1 << 25));
        rd(REQ + 12, q);
        check("R9 clear wins over set", q, 32'h0000_0302);

        // sweep: random configs, inputs, thresholds and bases
        for (int it = 0; it < 400; it++) begin
            int s;
            logic [31:0] d;
            step_rand();
            s = int'(rs % 16) + 1;
            d = cfg(int'(rs[7:4]), int'(rs[8]), int'(rs[9] | rs[10]), int'(rs[11]));
            if (rs[12]) d = d | (32'h1 << 30);
            if (rs[13] && rs[14]) d = d | (32'h1 << 25);
            wr_req(s, d);
            step_rand();
            src_in = rs[15:0];
            if ((it % 4) == 0) begin
                wr_ctl(0, 32'(rs[19:16] & 4'h7));
                wr_ctl(1, 32'(rs[23:20] & 4'h7));
                step_rand();
                wr_ctl(2, rs);
                step_rand();
                wr_ctl(3, rs);
            end
            #1;
            check_outs("R5 R6 R7 R8 sweep");
            step_rand();
            s = int'(rs % 16) + 1;
            rd(REQ + s, q);
            check("R10 sweep readback", q, exp_rd(s));
        end

        // every threshold pair value on the final configuration
        for (int th = 0; th < 16; th++) begin
            wr_ctl(0, 32'(th));
            wr_ctl(1, 32'(15 - th));
            #1;
            check_outs("R5 threshold sweep");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule